// File: doc/BRIEF.md
# Arithmetic Status Word Unit

This block is the add/subtract datapath with its status word, as used in the execute stage of a 16-bit processor. It takes two operands, a subtract select and a byte/word size select. It drives the sum or difference combinationally, along with six status conditions derived from that result:

- carry or borrow,
- even parity,
- half-carry across the nibble boundary,
- zero,
- sign,
- signed overflow.

When the write enable is high at a clock edge, those conditions are captured into a 16-bit status word. The word also carries three software-owned control bits: single-step trap, interrupt enable and string direction. Each control bit has its own set and clear strobes.

In byte mode, only the low byte takes part in the operation and the upper result byte reads zero. Carry, sign and overflow are then taken at bit 7. Parity always covers the low eight result bits, whatever the size. The bits of the word that carry no condition read as fixed constants.

Top module: `arith_flag_unit`

## Requirements
- R1: In word mode with op_sub=0, result equals (op_a + op_b) mod 2^16, and the captured carry (flag bit 0) is the carry out of bit 15.
- R2: With op_sub=1, result equals (op_a - op_b) modulo the selected size, and the captured carry (bit 0) is 1 exactly when the unsigned op_b exceeds the unsigned op_a at that size (borrow).
- R3: The captured half-carry (bit 4) is the carry out of bit 3 on add, and the borrow into bit 4 on subtract (low nibble of op_b greater than low nibble of op_a).
- R4: The captured parity (bit 2) is 1 when result[7:0] holds an even number of ones, and 0 otherwise; result[15:8] never affects it.
- R5: The captured zero flag (bit 6) is 1 exactly when the result at the selected size is all zeros.
- R6: The captured sign flag (bit 7) equals result bit 7 in byte mode and result bit 15 in word mode.
- R7: The captured overflow flag (bit 11) is 1 exactly when the signed result falls outside the signed range of the selected size.
- R8: With op_byte=1, result[15:8] is zero, op_a[15:8] and op_b[15:8] are ignored, and carry comes from bit 7.
- R9: The six status bits change only at a rising clock edge with wr_en=1. With wr_en=0 they hold, whatever the operands are.
- R10: Control strobe index 0 drives trap (bit 8), index 1 drives interrupt enable (bit 9) and index 2 drives direction (bit 10). A set strobe writes 1 and a clear strobe writes 0 at the next edge. Clear wins when both are high. wr_en never touches these bits.
- R11: After reset, flags reads 16'hF002: every status and control bit is 0.
- R12: Flag bits 1 and 12 to 15 always read 1, and bits 3 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 16 | First operand (minuend on subtract) |
| op_b | input | 16 | Second operand (subtrahend on subtract) |
| op_sub | input | 1 | 1 selects subtract, 0 selects add |
| op_byte | input | 1 | 1 selects byte size, 0 selects word size |
| wr_en | input | 1 | Capture the status conditions at the next edge |
| ctl_set | input | 3 | Per-bit set strobes for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Per-bit clear strobes, same indexing, priority over set |
| result | output | 16 | Combinational sum or difference |
| flags | output | 16 | Registered status word |

## Verification
The hardest case to reach from the ports is overflow without carry, and its reverse, at each operand size. Carry and overflow come from different carries, and they separate only for particular sign patterns. The stimulus therefore uses hand-picked operand pairs: byte 66+69 (overflow and sign, no carry), byte -12+18 (carry, no overflow), 0xFFFF+1 (carry and zero) and the matching subtractions. Byte cases are run with junk in the upper operand bytes. Hold behaviour is checked with the operands changing while wr_en is low and the control strobes are active.

// File: rtl/afu_pkg.sv
package afu_pkg;
   localparam int FLAG_W  = 16;
   localparam int CF_POS  = 0;
   localparam int PF_POS  = 2;
   localparam int AF_POS  = 4;
   localparam int ZF_POS  = 6;
   localparam int SF_POS  = 7;
   localparam int TF_POS  = 8;
   localparam int IF_POS  = 9;
   localparam int DF_POS  = 10;
   localparam int OF_POS  = 11;
   localparam int CTL_N   = 3;
   localparam logic [FLAG_W-1:0] FIXED_ONES = 16'hF002;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
   } status_t;
endpackage

// File: rtl/afu_slice.sv
module afu_slice #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   logic [W:0] full;

   assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   assign sum_o  = full[W-1:0];
   assign cout_o = full[W];
endmodule

// File: rtl/afu_addsub.sv
module afu_addsub #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [WORD_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              byte_i,
   output logic [WORD_W-1:0] sum_o,
   output logic              cout_o,
   output logic              cmsb_o,
   output logic              cnib_o
);
   localparam int NSZ   = 2;
   localparam int BYTE_I = 0;
   localparam int WORD_I = 1;

   logic [WORD_W-1:0] b_eff;
   logic [NSZ-1:0]    cout_s;
   logic [NSZ-1:0]    cmsb_s;
   logic [WORD_W-1:0] sum_s [NSZ];

   assign b_eff = sub_i ? ~b_i : b_i;

   for (genvar s = 0; s < NSZ; s++) begin : g_size
      localparam int SZ = (s == BYTE_I) ? BYTE_W : WORD_W;
      logic [SZ-1:0] part;

      afu_slice #(.W(SZ)) u_slice (
         .a_i    (a_i[SZ-1:0]),
         .b_i    (b_eff[SZ-1:0]),
         .cin_i  (sub_i),
         .sum_o  (part),
         .cout_o (cout_s[s])
      );

      // carry into the top bit recovered from that bit's sum and inputs
      assign cmsb_s[s] = part[SZ-1] ^ a_i[SZ-1] ^ b_eff[SZ-1];

      if (SZ < WORD_W) begin : g_ext
         assign sum_s[s] = {{(WORD_W-SZ){1'b0}}, part};
      end else begin : g_full
         assign sum_s[s] = part;
      end
   end

   assign sum_o  = byte_i ? sum_s[BYTE_I]  : sum_s[WORD_I];
   assign cout_o = byte_i ? cout_s[BYTE_I] : cout_s[WORD_I];
   assign cmsb_o = byte_i ? cmsb_s[BYTE_I] : cmsb_s[WORD_I];
   assign cnib_o = sum_o[NIB_W] ^ a_i[NIB_W] ^ b_eff[NIB_W];
endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen
   import afu_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int PAR_W  = 8
) (
   input  logic [WORD_W-1:0] sum_i,
   input  logic              sub_i,
   input  logic              byte_i,
   input  logic              cout_i,
   input  logic              cmsb_i,
   input  logic              cnib_i,
   output status_t           st_o
);
   logic par_odd;
   logic byte_zero;
   logic word_zero;

   if (PAR_W == 1) begin : g_par1
      assign par_odd = sum_i[0];
   end else begin : g_parn
      assign par_odd = ^sum_i[PAR_W-1:0];
   end

   assign byte_zero = (sum_i[BYTE_W-1:0] == '0);
   assign word_zero = (sum_i == '0);

   always_comb begin
      st_o.cf = cout_i ^ sub_i;
      st_o.af = cnib_i ^ sub_i;
      st_o.of = cmsb_i ^ cout_i;
      st_o.pf = ~par_odd;
      st_o.zf = byte_i ? byte_zero : word_zero;
      st_o.sf = byte_i ? sum_i[BYTE_W-1] : sum_i[WORD_W-1];
   end
endmodule

// File: rtl/afu_ctl_bits.sv
module afu_ctl_bits #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[i] <= 1'b0;
         else if (clr_i[i]) q_o[i] <= 1'b0;
         else if (set_i[i]) q_o[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import afu_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int NIB_W  = 4,
   parameter int PAR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic              op_sub,
   input  logic              op_byte,
   input  logic              wr_en,
   input  logic [CTL_N-1:0]  ctl_set,
   input  logic [CTL_N-1:0]  ctl_clr,
   output logic [WORD_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);
   if (WORD_W <= BYTE_W) begin : g_bad_word
      $error("WORD_W must exceed BYTE_W");
   end
   if (NIB_W < 1 || NIB_W >= BYTE_W) begin : g_bad_nib
      $error("NIB_W must lie inside the byte");
   end
   if (PAR_W < 1 || PAR_W > BYTE_W) begin : g_bad_par
      $error("PAR_W must lie inside the byte");
   end

   logic              cout;
   logic              cmsb;
   logic              cnib;
   status_t           st_next;
   status_t           st_q;
   logic [CTL_N-1:0]  ctl_q;

   afu_addsub #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_addsub (
      .a_i    (op_a),
      .b_i    (op_b),
      .sub_i  (op_sub),
      .byte_i (op_byte),
      .sum_o  (result),
      .cout_o (cout),
      .cmsb_o (cmsb),
      .cnib_o (cnib)
   );

   afu_flag_gen #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .PAR_W(PAR_W)) u_flag_gen (
      .sum_i  (result),
      .sub_i  (op_sub),
      .byte_i (op_byte),
      .cout_i (cout),
      .cmsb_i (cmsb),
      .cnib_i (cnib),
      .st_o   (st_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= '0;
      else if (wr_en) st_q <= st_next;
   end

   afu_ctl_bits #(.N(CTL_N)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ctl_set),
      .clr_i (ctl_clr),
      .q_o   (ctl_q)
   );

   always_comb begin
      flags         = FIXED_ONES;
      flags[CF_POS] = st_q.cf;
      flags[PF_POS] = st_q.pf;
      flags[AF_POS] = st_q.af;
      flags[ZF_POS] = st_q.zf;
      flags[SF_POS] = st_q.sf;
      flags[OF_POS] = st_q.of;
      flags[TF_POS] = ctl_q[0];
      flags[IF_POS] = ctl_q[1];
      flags[DF_POS] = ctl_q[2];
   end
endmodule

// File: rtl/afu_checker.sv
module afu_checker
   import afu_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              op_byte,
   input logic              wr_en,
   input logic [CTL_N-1:0]  ctl_set,
   input logic [CTL_N-1:0]  ctl_clr,
   input logic [15:0]       result,
   input logic [FLAG_W-1:0] flags
);
   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && ctl_set == '0 && ctl_clr == '0) |=> $stable(flags));

   // R5
   zero_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> flags[ZF_POS] == ($past(result) == 16'h0000));

   // R6
   sign_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> flags[SF_POS] == ($past(op_byte) ? $past(result[7]) : $past(result[15])));

   // R4
   parity_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> flags[PF_POS] == ~(^$past(result[7:0])));

   // R8
   byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_byte |-> result[15:8] == 8'h00);

   // R10
   dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clr[2] |=> !flags[DF_POS]);

   // R10
   trap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_set[0] && !ctl_clr[0]) |=> flags[TF_POS]);

   // R10
   ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_set[1] && !ctl_clr[1]) |=> flags[IF_POS] == $past(flags[IF_POS]));
endmodule

bind arith_flag_unit afu_checker u_chk (.*);

// File: tb/sim_arith_flag_unit.sv
`timescale 1ns/1ps
module sim_arith_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        op_sub = 1'b0, op_byte = 1'b0, wr_en = 1'b0;
   logic [2:0]  ctl_set = '0, ctl_clr = '0;
   logic [15:0] result, flags;

   int n_cmp = 0, n_bad = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [5:0]  m_st = '0;   // cf pf af zf sf of
   logic [2:0]  m_ctl = '0;

   always #10 clk = ~clk;

   arith_flag_unit u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .op_sub(op_sub), .op_byte(op_byte), .wr_en(wr_en), .ctl_set(ctl_set),
      .ctl_clr(ctl_clr), .result(result), .flags(flags));

   function automatic logic [15:0] model_word();
      logic [15:0] w;
      w = 16'hF002;
      w[0] = m_st[5]; w[2] = m_st[4]; w[4] = m_st[3];
      w[6] = m_st[2]; w[7] = m_st[1]; w[11] = m_st[0];
      w[8] = m_ctl[0]; w[9] = m_ctl[1]; w[10] = m_ctl[2];
      return w;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input string tag);
      exp_q.push_back(model_word());
      tag_q.push_back(tag);
   endtask

   task automatic op(input int a, input int b, input bit sub, input bit byt, input string tag);
      int mask, msb, am, bm, r, sa, sb, sr, ones;
      @(negedge clk);
      op_a = a[15:0]; op_b = b[15:0]; op_sub = sub; op_byte = byt;
      wr_en = 1'b1; ctl_set = '0; ctl_clr = '0;
      mask = byt ? 'hFF : 'hFFFF; msb = byt ? 7 : 15;
      am = a & mask; bm = b & mask;
      r = sub ? ((am - bm) & mask) : ((am + bm) & mask);
      #1 check({tag, " result"}, result, r[15:0]);
      sa = (am >> msb) & 1; sb = (bm >> msb) & 1; sr = (r >> msb) & 1;
      ones = $countones(r[7:0]);
      m_st[5] = sub ? (am < bm) : ((am + bm) > mask);
      m_st[4] = (ones % 2) == 0;
      m_st[3] = sub ? ((am & 15) < (bm & 15)) : (((am & 15) + (bm & 15)) > 15);
      m_st[2] = (r == 0);
      m_st[1] = sr[0];
      m_st[0] = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
      push(tag);
      @(posedge clk);
   endtask

   task automatic idle(input int a, input int b, input logic [2:0] s, input logic [2:0] c, input string tag);
      @(negedge clk);
      op_a = a[15:0]; op_b = b[15:0]; op_sub = ~op_sub; op_byte = ~op_byte;
      wr_en = 1'b0; ctl_set = s; ctl_clr = c;
      m_ctl = (m_ctl | s) & ~c;
      push(tag);
      @(posedge clk);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) check(tag_q.pop_front(), flags, exp_q.pop_front());
      end
   end

   initial begin : watchdog
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #5 check("R11 R12 reset word", flags, 16'hF002);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk) check("R11 after release", flags, 16'hF002);

      op('hFFFF, 1, 0, 0, "R1 R5 ffff+1 carry zero");
      op(66, 69, 0, 1, "R7 R6 byte 66+69 overflow sign");
      op('hAB00 | 'hF4, 'h1200 | 18, 0, 1, "R8 byte -12+18 carry no overflow");
      op('h126F, 'h3465, 0, 0, "R1 R3 word 126f+3465");
      op('h8000, 'hC800, 0, 0, "R7 R1 word 8000+c800");
      op('hB1, 'hAB, 0, 1, "R3 R4 byte b1+ab");
      op('h0003, 'h0005, 1, 0, "R2 word 3-5 borrow");
      op('h8000, 1, 1, 0, "R2 R7 word 8000-1 overflow");
      op('h0010, 'h0001, 1, 1, "R3 byte half borrow");
      op('h5A5A, 'h5A5A, 1, 0, "R5 word zero difference");
      op('hFF00, 'h0100, 0, 0, "R4 parity low byte only");
      op('h7F, 'h80, 1, 1, "R7 R2 byte 7f-80");
      op(-30, 14, 0, 1, "R6 byte -30+14");

      idle('h1234, 'h4321, 3'b000, 3'b000, "R9 hold no write");
      idle('hFFFF, 'hFFFF, 3'b101, 3'b000, "R10 set trap dir");
      idle('h0, 'h0, 3'b010, 3'b000, "R10 set ie");
      op('h0001, 'h0001, 0, 0, "R10 write keeps ctl");
      idle('h0, 'h0, 3'b111, 3'b100, "R10 clear wins dir");
      idle('h0, 'h0, 3'b000, 3'b011, "R10 clear trap ie");

      @(negedge clk);
      wr_en = 1'b0; ctl_set = '0; ctl_clr = '0;
      repeat (3) @(posedge clk);
      #6;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule